// File: doc/BRIEF.md
# Register-Launched Dual-Port Transfer Bridge

This block is an APB slave register file that lets software run single transfers on one of two downstream request/acknowledge master ports. Software writes a channel's enable, direction, size code, target address and write data into that channel's registers. It then writes the launch register. The bridge issues one read or write of 1, 2 or 4 bytes on the chosen port. When a read completes, the returned data goes into the channel's capture register. When any transfer completes without error, the channel's sticky done flag is set in a shared status register.

The launch write stalls the APB bus: PREADY stays low until the downstream port answers or a timeout expires. Software therefore sees the result as soon as the launch write ends, and can also wait on a single interrupt line that is the OR of the two done flags.

Top module: `bridge2ch_top`

## Requirements
- R1: After reset, offset 0x00 reads 0x000000A1. Offsets 0x4C and 0x5C read 0x0044EEE4, 0x50 reads 0x0055AAFF, 0x54 and 0x60 read 0x00117717, and 0x58 reads 0xFFAA5500. All channel registers, the status register (0x48) and the capture registers read 0. `irq` is low and no `dn_req` is high.
- R2: The register index is PADDR[11:2]. Indices 0 to 36 (offsets up to 0x90) are storage that reads back what was last written, except the status register. Offsets from 0x94 up to 0xFFC read 0, and writes to them are ignored.
- R3: The channel registers sit at offsets base+0x0 (enable, bit 0), +0x4 (direction), +0x8 (size code), +0xC (address) and +0x10 (write data), with base 0x10 for channel 0 and 0x28 for channel 1. Any write to 0x04 launches a transfer and is stored. Channel 0 wins when both channels are enabled. With neither enabled, nothing is issued and the write completes with no wait state.
- R4: During a transfer the selected port's `dn_we` is the inverse of direction bit 0 (1 means read). `dn_addr` is the address register. `dn_size` is size-code bits 1:0. `dn_wdata` is the write data with the bytes above the transfer length forced to zero.
- R5: A size code with any bit above bit 1 set, or with the value 2, is rejected. No request is issued, no register changes except the launch register, and the launch write completes with no wait state.
- R6: A read that ends with `dn_ack` and without `dn_err` stores `dn_rdata` into 0x84 (channel 0) or 0x90 (channel 1). The value is zero-extended above the transfer length (code 0: bits 7:0, code 1: bits 15:0, code 3: all 32 bits). Write transfers leave both capture registers unchanged.
- R7: A transfer that ends without error sets status bit 16 (channel 0) or bit 17 (channel 1). The bit stays set until software writes 1 to it. Writing 0 has no effect. The other status bits read 0. `irq` is the OR of bits 16 and 17.
- R8: A response with `dn_err` high ends the transfer with no change to the status bits or the capture registers.
- R9: If no response arrives, `dn_req` stays high for exactly TMO_CYCLES (default 255) cycles. The transfer then ends as an error.
- R10: PREADY is low from the access cycle of a launching write until the cycle after the response. `dn_req` is high on at most one port, starts in the cycle after that access cycle, and drops in the cycle after the response. For a response in the N-th request cycle, the launch write sees N+1 wait cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, low while a launched transfer runs |
| dn_req | output | 2 | Per-port request |
| dn_we | output | 2 | Per-port write enable |
| dn_addr | output | 2x32 | Per-port address |
| dn_wdata | output | 2x32 | Per-port write data, length-masked |
| dn_size | output | 2x2 | Per-port size code |
| dn_ack | input | 2 | Per-port acknowledge |
| dn_err | input | 2 | Per-port error response |
| dn_rdata | input | 2x32 | Per-port read data |
| irq | output | 1 | OR of the two done flags |

## Verification
A sequencer stuck in its busy state holds PREADY low. The bench sees this in the wait-cycle count of the same launch write, and the checker sees it once the request run exceeds TMO_CYCLES. A wrong channel latch or priority decision drives the request onto the wrong port in the first request cycle. A wrong capture, size mask or status update is visible at the first APB read of 0x48, 0x84 or 0x90 after the launch write. A flag set on an error response shows up at once as an `irq` rise in the cycle after the error.

// File: rtl/b2c_pkg.sv
package b2c_pkg;
  localparam int NCH        = 2;
  localparam int DW         = 32;
  localparam int NREGS      = 37;
  localparam int IDX_VER    = 0;
  localparam int IDX_LAUNCH = 1;
  localparam int IDX_STAT   = 18;
  localparam int IDX_EW0    = 19;
  localparam int IDX_EB0    = 20;
  localparam int IDX_EW1    = 21;
  localparam int IDX_EB1    = 22;
  localparam int IDX_ER0    = 23;
  localparam int IDX_ER1    = 24;
  localparam int IDX_CAP0   = 33;
  localparam int IDX_CAP1   = 36;
  localparam int BASE0      = 4;
  localparam int BASE1      = 10;
  localparam int OFS_EN     = 0;
  localparam int OFS_DIR    = 1;
  localparam int OFS_SIZE   = 2;
  localparam int OFS_ADDR   = 3;
  localparam int OFS_WDATA  = 4;
  localparam int STAT_BIT0  = 16;
  localparam logic [DW-1:0] STAT_MASK = DW'(((1 << NCH) - 1) << STAT_BIT0);

  typedef enum logic [1:0] {XS_IDLE, XS_BUSY, XS_FIN} xs_t;

  function automatic int ch_base(int c);
    return (c == 0) ? BASE0 : BASE1;
  endfunction

  function automatic logic [DW-1:0] reset_val(int idx);
    case (idx)
      IDX_VER:          return 32'h0000_00A1;
      IDX_EW0, IDX_ER0: return 32'h0044_EEE4;
      IDX_EB0:          return 32'h0055_AAFF;
      IDX_EW1, IDX_ER1: return 32'h0011_7717;
      IDX_EB1:          return 32'hFFAA_5500;
      default:          return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] size_mask(logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/b2c_regs.sv
module b2c_regs
  import b2c_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DW-1:0]          wr_data,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [DW-1:0]          rd_data,
  input  logic                   cap_en,
  input  logic                   cap_ch,
  input  logic [DW-1:0]          cap_data,
  input  logic [NCH-1:0]         done_set,
  output logic [NCH-1:0]         cfg_en,
  output logic [NCH-1:0]         cfg_rd,
  output logic [NCH-1:0][DW-1:0] cfg_size,
  output logic [NCH-1:0][DW-1:0] cfg_addr,
  output logic [NCH-1:0][DW-1:0] cfg_wdata,
  output logic [NCH-1:0]         done_bits
);
  localparam int IW = $clog2(NREGS);

  logic [DW-1:0] mem_q [NREGS];
  logic [DW-1:0] mem_d [NREGS];
  logic          wr_hit;

  assign wr_hit = wr_en && (wr_idx < IDX_W'(NREGS));

  always_comb begin
    for (int i = 0; i < NREGS; i++) mem_d[i] = mem_q[i];
    if (wr_hit) begin
      if (int'(wr_idx) == IDX_STAT)
        mem_d[IDX_STAT] = mem_q[IDX_STAT] & ~(wr_data & STAT_MASK);
      else
        mem_d[wr_idx[IW-1:0]] = wr_data;
    end
    if (cap_en) mem_d[cap_ch ? IDX_CAP1 : IDX_CAP0] = cap_data;
    for (int c = 0; c < NCH; c++)
      if (done_set[c]) mem_d[IDX_STAT][STAT_BIT0 + c] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem_q[i] <= reset_val(i);
    end else begin
      for (int i = 0; i < NREGS; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_data = (rd_idx < IDX_W'(NREGS)) ? mem_q[rd_idx[IW-1:0]] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_cfg
    assign cfg_en[c]    = mem_q[ch_base(c) + OFS_EN][0];
    assign cfg_rd[c]    = mem_q[ch_base(c) + OFS_DIR][0];
    assign cfg_size[c]  = mem_q[ch_base(c) + OFS_SIZE];
    assign cfg_addr[c]  = mem_q[ch_base(c) + OFS_ADDR];
    assign cfg_wdata[c] = mem_q[ch_base(c) + OFS_WDATA];
    assign done_bits[c] = mem_q[IDX_STAT][STAT_BIT0 + c];
  end
endmodule

// File: rtl/b2c_xfer.sv
module b2c_xfer
  import b2c_pkg::*;
#(
  parameter int TMO_CYCLES = 255
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch_wr,
  input  logic [NCH-1:0]         cfg_en,
  input  logic [NCH-1:0]         cfg_rd,
  input  logic [NCH-1:0][DW-1:0] cfg_size,
  input  logic [NCH-1:0][DW-1:0] cfg_addr,
  input  logic [NCH-1:0][DW-1:0] cfg_wdata,
  output logic                   stall,
  output logic [NCH-1:0]         dn_req,
  output logic [NCH-1:0]         dn_we,
  output logic [NCH-1:0][DW-1:0] dn_addr,
  output logic [NCH-1:0][DW-1:0] dn_wdata,
  output logic [NCH-1:0][1:0]    dn_size,
  input  logic [NCH-1:0]         dn_ack,
  input  logic [NCH-1:0]         dn_err,
  input  logic [NCH-1:0][DW-1:0] dn_rdata,
  output logic                   cap_en,
  output logic                   cap_ch,
  output logic [DW-1:0]          cap_data,
  output logic [NCH-1:0]         done_set
);
  localparam int CW = $clog2(TMO_CYCLES + 1);

  xs_t           st_q, st_d;
  logic          ch_q, ch_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pick, size_ok, go;
  logic          resp, good, expired;

  // channel 0 has priority; channel 1 only when channel 0 is off
  assign pick    = !cfg_en[0];
  assign size_ok = (cfg_size[pick][DW-1:2] == '0) && (cfg_size[pick][1:0] != 2'd2);
  assign go      = launch_wr && (st_q == XS_IDLE) && (|cfg_en) && size_ok;

  assign resp    = dn_ack[ch_q] || dn_err[ch_q];
  assign good    = dn_ack[ch_q] && !dn_err[ch_q];
  assign expired = (cnt_q == CW'(TMO_CYCLES - 1));

  always_comb begin
    st_d     = st_q;
    ch_d     = ch_q;
    cnt_d    = cnt_q;
    cap_en   = 1'b0;
    done_set = '0;
    case (st_q)
      XS_IDLE: if (go) begin
        st_d  = XS_BUSY;
        ch_d  = pick;
        cnt_d = '0;
      end
      XS_BUSY: begin
        if (resp || expired) begin
          st_d           = XS_FIN;
          cap_en         = good && cfg_rd[ch_q];
          done_set[ch_q] = good;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= XS_IDLE;
      ch_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      ch_q  <= ch_d;
      cnt_q <= cnt_d;
    end
  end

  assign stall    = (st_q == XS_BUSY) || go;
  assign cap_ch   = ch_q;
  assign cap_data = dn_rdata[ch_q] & size_mask(cfg_size[ch_q][1:0]);

  for (genvar c = 0; c < NCH; c++) begin : g_port
    assign dn_req[c]   = (st_q == XS_BUSY) && (ch_q == 1'(c));
    assign dn_we[c]    = !cfg_rd[c];
    assign dn_addr[c]  = cfg_addr[c];
    assign dn_size[c]  = cfg_size[c][1:0];
    assign dn_wdata[c] = cfg_wdata[c] & size_mask(cfg_size[c][1:0]);
  end
endmodule

// File: rtl/bridge2ch_top.sv
module bridge2ch_top
  import b2c_pkg::*;
#(
  parameter int AW         = 12,
  parameter int TMO_CYCLES = 255
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [AW-1:0]          paddr,
  input  logic [DW-1:0]          pwdata,
  output logic [DW-1:0]          prdata,
  output logic                   pready,
  output logic [NCH-1:0]         dn_req,
  output logic [NCH-1:0]         dn_we,
  output logic [NCH-1:0][DW-1:0] dn_addr,
  output logic [NCH-1:0][DW-1:0] dn_wdata,
  output logic [NCH-1:0][1:0]    dn_size,
  input  logic [NCH-1:0]         dn_ack,
  input  logic [NCH-1:0]         dn_err,
  input  logic [NCH-1:0][DW-1:0] dn_rdata,
  output logic                   irq
);
  localparam int IDX_W = AW - 2;

  logic                   rst_s1_q, rst_sync_n;
  logic [IDX_W-1:0]       idx;
  logic                   access, launch_wr, wr_en, stall;
  logic                   cap_en, cap_ch;
  logic [DW-1:0]          cap_data;
  logic [NCH-1:0]         done_set, done_bits;
  logic [NCH-1:0]         cfg_en, cfg_rd;
  logic [NCH-1:0][DW-1:0] cfg_size, cfg_addr, cfg_wdata;
  logic                   unused_lsb;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  assign idx        = paddr[AW-1:2];
  assign unused_lsb = ^paddr[1:0];
  assign access     = psel && penable;
  assign launch_wr  = access && pwrite && (int'(idx) == IDX_LAUNCH);
  assign pready     = !stall;
  assign wr_en      = access && pwrite && pready;
  assign irq        = |done_bits;

  b2c_regs #(.IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_idx   (idx),
    .wr_data  (pwdata),
    .rd_idx   (idx),
    .rd_data  (prdata),
    .cap_en   (cap_en),
    .cap_ch   (cap_ch),
    .cap_data (cap_data),
    .done_set (done_set),
    .cfg_en   (cfg_en),
    .cfg_rd   (cfg_rd),
    .cfg_size (cfg_size),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .done_bits(done_bits)
  );

  b2c_xfer #(.TMO_CYCLES(TMO_CYCLES)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .launch_wr(launch_wr),
    .cfg_en   (cfg_en),
    .cfg_rd   (cfg_rd),
    .cfg_size (cfg_size),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .stall    (stall),
    .dn_req   (dn_req),
    .dn_we    (dn_we),
    .dn_addr  (dn_addr),
    .dn_wdata (dn_wdata),
    .dn_size  (dn_size),
    .dn_ack   (dn_ack),
    .dn_err   (dn_err),
    .dn_rdata (dn_rdata),
    .cap_en   (cap_en),
    .cap_ch   (cap_ch),
    .cap_data (cap_data),
    .done_set (done_set)
  );
endmodule

// File: rtl/b2c_checker.sv
module b2c_checker
  import b2c_pkg::*;
#(
  parameter int TMO_CYCLES = 255
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pready,
  input logic [NCH-1:0] dn_req,
  input logic [NCH-1:0] dn_ack,
  input logic [NCH-1:0] dn_err,
  input logic           irq
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (|dn_req) run_q <= run_q + 16'd1;
    else run_q <= '0;
  end

  a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_req));

  a_r10_stall_during_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_req) |-> !pready);

  a_r10_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dn_req & (dn_ack | dn_err))) |=> (dn_req == '0));

  a_r9_req_window: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 16'(TMO_CYCLES));

  a_r7_irq_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(dn_req & dn_ack & ~dn_err)));

  a_r8_err_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dn_req & dn_err)) |=> !$rose(irq));
endmodule

bind bridge2ch_top b2c_checker #(.TMO_CYCLES(TMO_CYCLES)) u_b2c_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .pready(pready),
  .dn_req(dn_req),
  .dn_ack(dn_ack),
  .dn_err(dn_err),
  .irq   (irq)
);

// File: tb/tb_bridge2ch_top.sv
`timescale 1ns/1ps
module tb_bridge2ch_top;
  localparam int TMO = 255;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             psel, penable, pwrite;
  logic [11:0]      paddr;
  logic [31:0]      pwdata, prdata;
  logic             pready;
  logic [1:0]       dn_req, dn_we, dn_ack, dn_err;
  logic [1:0][31:0] dn_addr, dn_wdata, dn_rdata;
  logic [1:0][1:0]  dn_size;
  logic             irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // responder control and observations
  int          r_mode;
  int          r_lat;
  logic [31:0] r_data;
  int          rq_cnt [2];
  logic        ob_we  [2];
  logic [31:0] ob_addr [2];
  logic [31:0] ob_wdata [2];
  logic [1:0]  ob_size [2];

  // bench model
  logic [1:0]  m_done;
  logic [31:0] m_cap [2];

  bridge2ch_top #(.AW(12), .TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_size(dn_size), .dn_ack(dn_ack), .dn_err(dn_err), .dn_rdata(dn_rdata),
    .irq(irq));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (dn_req[c]) begin
        if (rq_cnt[c] == 0) begin
          ob_we[c] = dn_we[c]; ob_addr[c] = dn_addr[c];
          ob_wdata[c] = dn_wdata[c]; ob_size[c] = dn_size[c];
        end
        rq_cnt[c]++;
        if (!dn_ack[c] && !dn_err[c] && r_mode != 2 && rq_cnt[c] > r_lat) begin
          dn_ack[c]   = (r_mode == 0);
          dn_err[c]   = (r_mode == 1);
          dn_rdata[c] = r_data;
        end
      end else begin
        dn_ack[c] = 1'b0;
        dn_err[c] = 1'b0;
      end
    end
  end

  function automatic logic [31:0] mask_of(logic [1:0] code);
    return (code == 2'd0) ? 32'hFF : (code == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [11:0] base_of(int c);
    return (c == 0) ? 12'h010 : 12'h028;
  endfunction

  task automatic chk(string msg, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, output int stalls);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; #0.5; stalls = 0;
    while (!pready) begin stalls++; @(negedge clk); #0.5; end
    @(posedge clk); #0.5; psel = 0; penable = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #0.5; d = prdata;
    @(posedge clk); #0.5; psel = 0; penable = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    int s;
    apb_wr(a, d, s);
  endtask

  task automatic trial(input logic [1:0] en, input logic [1:0][31:0] dir, size, addr, wdata,
                       input int rm, input int lat, input logic [31:0] rdata);
    int st, ch, exp_st, exp_n;
    bit ok;
    logic [31:0] trig, v;
    for (int c = 0; c < 2; c++) begin
      wr(base_of(c),        {$urandom} & 32'hFFFF_FFFE | 32'(en[c]));
      wr(base_of(c) + 4,    dir[c]);
      wr(base_of(c) + 8,    size[c]);
      wr(base_of(c) + 12,   addr[c]);
      wr(base_of(c) + 16,   wdata[c]);
    end
    r_mode = rm; r_lat = lat; r_data = rdata;
    rq_cnt[0] = 0; rq_cnt[1] = 0;
    trig = $urandom;
    apb_wr(12'h004, trig, st);
    ch = en[0] ? 0 : (en[1] ? 1 : -1);
    ok = (ch >= 0) && (size[ch][31:2] == 0) && (size[ch][1:0] != 2'd2);
    exp_st = !ok ? 0 : (rm == 2 ? TMO + 1 : lat + 2);
    chk("R10/R5 launch wait cycles", st, exp_st);
    for (int c = 0; c < 2; c++) begin
      exp_n = (ok && c == ch) ? (rm == 2 ? TMO : lat + 1) : 0;
      chk(rm == 2 ? "R9 request cycles" : "R3/R5 request cycles", rq_cnt[c], exp_n);
    end
    if (ok) begin
      chk("R4 dn_we",    ob_we[ch],    !dir[ch][0]);
      chk("R4 dn_addr",  ob_addr[ch],  addr[ch]);
      chk("R4 dn_size",  ob_size[ch],  size[ch][1:0]);
      chk("R4 dn_wdata", ob_wdata[ch], wdata[ch] & mask_of(size[ch][1:0]));
      if (rm == 0) begin
        m_done[ch] = 1'b1;
        if (dir[ch][0]) m_cap[ch] = rdata & mask_of(size[ch][1:0]);
      end
    end
    apb_rd(12'h048, v); chk("R7/R8 status", v, {14'b0, m_done, 16'b0});
    apb_rd(12'h084, v); chk("R6/R8 capture ch0", v, m_cap[0]);
    apb_rd(12'h090, v); chk("R6/R8 capture ch1", v, m_cap[1]);
    chk("R7 irq", irq, |m_done);
    apb_rd(12'h004, v); chk("R3 launch stored", v, trig);
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    dn_ack = '0; dn_err = '0; dn_rdata = '0;
    r_mode = 0; r_lat = 0; r_data = '0; rq_cnt[0] = 0; rq_cnt[1] = 0;
    m_done = '0; m_cap[0] = '0; m_cap[1] = '0;
    void'($urandom(32'd20250));
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset values
    apb_rd(12'h000, v); chk("R1 version", v, 32'h0000_00A1);
    apb_rd(12'h04C, v); chk("R1 endian 4C", v, 32'h0044_EEE4);
    apb_rd(12'h050, v); chk("R1 endian 50", v, 32'h0055_AAFF);
    apb_rd(12'h054, v); chk("R1 endian 54", v, 32'h0011_7717);
    apb_rd(12'h058, v); chk("R1 endian 58", v, 32'hFFAA_5500);
    apb_rd(12'h05C, v); chk("R1 endian 5C", v, 32'h0044_EEE4);
    apb_rd(12'h060, v); chk("R1 endian 60", v, 32'h0011_7717);
    apb_rd(12'h010, v); chk("R1 ch0 enable", v, 0);
    apb_rd(12'h034, v); chk("R1 ch1 address", v, 0);
    apb_rd(12'h048, v); chk("R1 status", v, 0);
    apb_rd(12'h084, v); chk("R1 capture ch0", v, 0);
    apb_rd(12'h090, v); chk("R1 capture ch1", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dn_req", dn_req, 0);

    // R2 window
    wr(12'h040, 32'hDEAD_BEEF); apb_rd(12'h040, v); chk("R2 storage readback", v, 32'hDEAD_BEEF);
    wr(12'h094, 32'h1234_5678); apb_rd(12'h094, v); chk("R2 above window reads 0", v, 0);
    wr(12'hFFC, 32'hFFFF_FFFF); apb_rd(12'hFFC, v); chk("R2 top of window reads 0", v, 0);

    // R3 no channel enabled
    trial(2'b00, {32'h1, 32'h1}, {32'h3, 32'h3}, {32'h11, 32'h22}, {32'h0, 32'h0}, 0, 0, 32'h0);
    // R3 priority, read ch0 of 1 byte (R6 mask)
    trial(2'b11, {32'h0, 32'h1}, {32'h3, 32'h0}, {32'hA000_0000, 32'h8000_0010},
          {32'h5555_5555, 32'h7777_7777}, 0, 2, 32'hCAFE_F00D);
    // ch1 only, 2-byte read
    trial(2'b10, {32'h1, 32'h0}, {32'h1, 32'h0}, {32'h8000_0004, 32'h0}, {32'h0, 32'h0}, 0, 0, 32'h1357_9BDF);
    // R6 write leaves capture; R4 2-byte write mask
    trial(2'b01, {32'h0, 32'h0}, {32'h0, 32'h1}, {32'h0, 32'h40}, {32'h0, 32'hAABB_CCDD}, 0, 1, 32'hFFFF_FFFF);
    // R5 size code 2 and upper bits
    trial(2'b01, {32'h0, 32'h1}, {32'h0, 32'h2}, {32'h0, 32'h0}, {32'h0, 32'h0}, 0, 0, 32'h0);
    trial(2'b10, {32'h1, 32'h0}, {32'h5, 32'h0}, {32'h0, 32'h0}, {32'h0, 32'h0}, 0, 0, 32'h0);
    // R8 error response on a read
    trial(2'b10, {32'h1, 32'h0}, {32'h3, 32'h0}, {32'h8, 32'h0}, {32'h0, 32'h0}, 1, 3, 32'h0BAD_0BAD);
    // R9 timeout on a read
    trial(2'b01, {32'h0, 32'h1}, {32'h0, 32'h3}, {32'h0, 32'hC}, {32'h0, 32'h0}, 2, 0, 32'h0);

    // R7 write-one-to-clear
    wr(12'h048, 32'h0000_0000);
    apb_rd(12'h048, v); chk("R7 write 0 keeps flags", v, 32'h0003_0000);
    wr(12'h048, 32'hFFFE_FFFF & 32'h0002_0000 | 32'h0000_FFFF);
    m_done[1] = 1'b0;
    apb_rd(12'h048, v); chk("R7 clear bit 17 only", v, 32'h0001_0000);
    chk("R7 irq held by bit 16", irq, 1);
    wr(12'h048, 32'h0001_0000); m_done[0] = 1'b0;
    apb_rd(12'h048, v); chk("R7 all clear", v, 0);
    chk("R7 irq low", irq, 0);

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [1:0][31:0] dir, size, addr, wdata;
      int sel, rm;
      for (int c = 0; c < 2; c++) begin
        dir[c] = $urandom; addr[c] = $urandom; wdata[c] = $urandom;
        sel = $urandom % 10;
        size[c] = (sel < 3) ? 32'd0 : (sel < 5) ? 32'd1 : (sel < 8) ? 32'd3 :
                  (sel == 8) ? 32'd2 : ({$urandom} | 32'h4);
      end
      rm = $urandom % 20;
      rm = (rm < 14) ? 0 : (rm < 19) ? 1 : 2;
      trial(2'($urandom), dir, size, addr, wdata, rm, $urandom % 6, $urandom);
      if ($urandom % 4 == 0) begin
        v = $urandom & 32'h0003_0000;
        wr(12'h048, v);
        m_done = m_done & ~v[17:16];
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule